// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits beside a two-wire bus master and frees the bus when a slave has been left holding the data line low, for example after an aborted transfer, a brown-out or a reset in the middle of a byte. On request it takes over the clock line and toggles it while it watches the data line. As soon as the data line is seen released during a clock-high phase, it stops toggling. It then places a start condition and a stop condition on the bus, so that every slave resynchronises and the bus is left idle. If the data line is still low after the last permitted pulse, the sequencer gives up, releases both lines and reports a failure.

Both lines are driven open-drain style. An output enable of 1 pulls the line low, and 0 releases it. The observed line levels come back on two inputs that pass through a synchroniser of `SYNC_STAGES` flops. Every timed phase first waits until its synchronised line has reached the level the phase expects, and then counts a programmable number of clock cycles. A count of 0 is treated as 1, so with `T = max(count,1)` a phase that waits for a line to change lasts `SYNC_STAGES + T` cycles. Because of this rule, a slave that stretches the clock simply lengthens the high phase.

Top module: `bus_unjam_seq`

## Requirements
- R1: During and after a synchronous reset (rst_n low), scl_oe, sda_oe, busy, done and fail are all 0, and no line is driven while busy is 0.
- R2: A go pulse while idle starts clock pulses. Each SCL low phase (scl_oe=1) lasts SYNC_STAGES+max(t_low,1) cycles, and each released high phase lasts SYNC_STAGES+max(t_high,1) cycles when no slave stretches the clock.
- R3: SDA is sampled at the end of every SCL-high phase. Pulsing stops after the first pulse in which SDA is seen high, so the number of pulses equals the index of that pulse (at least 1).
- R4: At most MAX_PULSES (default 9) pulses are issued. If SDA is still low at the end of the last one, both lines are released, no start or stop is generated, and fail is 1 in the same cycle as done.
- R5: On success the start condition is formed with SCL released: SDA is first held released for max(t_su,1) cycles, and then SDA is pulled low and held for SYNC_STAGES+max(t_hd,1) cycles before SCL goes low.
- R6: The stop follows the start. SCL is low for SYNC_STAGES+max(t_low,1) cycles, is then released for SYNC_STAGES+max(t_su,1) cycles while SDA is still low, and then SDA is released. The bus is then left free for SYNC_STAGES+max(t_buf,1) cycles before done.
- R7: done is a single-cycle pulse. The cycle count from the go edge to done equals the sum of the phase lengths given in R2 to R6, and busy is 1 from the go edge through the done cycle.
- R8: go is ignored while a sequence is running. Exactly one done is produced, the timing is unchanged, and the block returns to idle afterwards.
- R9: sda_oe changes only while SCL is released, both in the cycle of the change and in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Request to start a recovery sequence (sampled when idle) |
| t_low | input | CNT_W | Count for SCL low phases |
| t_high | input | CNT_W | Count for SCL high phases during pulsing |
| t_su | input | CNT_W | Start setup and stop setup count |
| t_hd | input | CNT_W | Start hold count |
| t_buf | input | CNT_W | Bus-free count after the stop |
| scl_in | input | 1 | Observed SCL line level (asynchronous) |
| sda_in | input | 1 | Observed SDA line level (asynchronous) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Set together with done when SDA never released |

## Verification
The bench builds the block with CNT_W=8, SYNC_STAGES=2 and MAX_PULSES=9. The short counts let four timing sets, including the all-zero set that exercises the count-of-zero rule, be swept against a modelled slave that releases SDA after 0 through 10 clock falls. This sweep covers every possible number of recovery pulses, the exact ninth-pulse boundary, and the give-up path one step beyond it. Line lengths, clock falls, start and stop events and total duration are all derived arithmetically from the programmed counts.

// File: rtl/bus_unjam_pkg.sv
// Shared definitions for the bus recovery sequencer.
// Assumes: included first in compile order.
package bus_unjam_pkg;

    // Sequencer phases; every phase except IDLE and FINISH is timed.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLK_LO,
        ST_CLK_HI,
        ST_STA_SU,
        ST_STA_HD,
        ST_STO_LO,
        ST_STO_SU,
        ST_BUS_FREE,
        ST_FINISH
    } unjam_state_e;

endpackage

// File: rtl/bus_unjam_sync.sv
// Multi-flop synchroniser for an asynchronous bus line level.
// Assumes: the line idles high, so the reset value is 1.
module bus_unjam_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= 1'b1;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the line level through the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bus_unjam_timer.sv
// Phase timer. It is loaded on entry to a phase and counts down only
// while the enable (line at its expected level) is high.
// Assumes: load is asserted only on the transition edge into a phase.
// A reload of 0 behaves like 1.
module bus_unjam_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    input  logic             en,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    // Reload on phase entry, otherwise count down while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt <= '0;
        else if (load)              cnt <= reload;
        else if (en && cnt > 1)     cnt <= cnt - 1'b1;
    end

    assign expire = en && (cnt <= 1);
endmodule

// File: rtl/bus_unjam_pulses.sv
// Counts recovery clock pulses and flags the last permitted one.
// Assumes: clr and inc are never asserted in the same cycle.
module bus_unjam_pulses #(
    parameter int MAX_PULSES = 9,
    localparam int PW = $clog2(MAX_PULSES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    logic [PW-1:0] cnt;

    // Clear at the start of a sequence, count each high phase entered.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (inc)      cnt <= cnt + 1'b1;
    end

    assign last = (cnt == PW'(MAX_PULSES));
endmodule

// File: rtl/bus_unjam_seq.sv
// Two-wire bus recovery sequencer (top). It pulses SCL until SDA is seen
// high during a high phase, then issues a start and a stop and reports done.
// It gives up after MAX_PULSES pulses and reports fail.
// Assumes: scl_in and sda_in reflect the wired-AND line levels. The outputs
// are output enables (1 = pull low) decoded from the state register.
module bus_unjam_seq
    import bus_unjam_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int MAX_PULSES  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] t_low,
    input  logic [CNT_W-1:0] t_high,
    input  logic [CNT_W-1:0] t_su,
    input  logic [CNT_W-1:0] t_hd,
    input  logic [CNT_W-1:0] t_buf,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             busy,
    output logic             done,
    output logic             fail
);
    unjam_state_e     state, nxt;
    logic             scl_s, sda_s;
    logic             lvl_ok, expire, load, fail_set, fail_r, last;
    logic [CNT_W-1:0] reload;

    bus_unjam_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst_n(rst_n), .d(scl_in), .q(scl_s));
    bus_unjam_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

    bus_unjam_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .reload(reload),
        .en(lvl_ok), .expire(expire));

    bus_unjam_pulses #(.MAX_PULSES(MAX_PULSES)) u_pulses (
        .clk(clk), .rst_n(rst_n),
        .clr(state == ST_IDLE && go),
        .inc(state == ST_CLK_LO && expire),
        .last(last));

    // Next-state, timer reload and the line level each phase waits for.
    always_comb begin
        nxt      = state;
        load     = 1'b0;
        reload   = '0;
        fail_set = 1'b0;
        lvl_ok   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    nxt = ST_CLK_LO; load = 1'b1; reload = t_low;
                end
            end
            ST_CLK_LO: begin
                lvl_ok = !scl_s;
                if (expire) begin
                    nxt = ST_CLK_HI; load = 1'b1; reload = t_high;
                end
            end
            ST_CLK_HI: begin
                lvl_ok = scl_s;
                if (expire) begin
                    load = 1'b1;
                    if (sda_s) begin
                        nxt = ST_STA_SU; reload = t_su;
                    end else if (last) begin
                        nxt = ST_FINISH; fail_set = 1'b1;
                    end else begin
                        nxt = ST_CLK_LO; reload = t_low;
                    end
                end
            end
            ST_STA_SU: begin
                lvl_ok = scl_s && sda_s;
                if (expire) begin
                    nxt = ST_STA_HD; load = 1'b1; reload = t_hd;
                end
            end
            ST_STA_HD: begin
                lvl_ok = !sda_s;
                if (expire) begin
                    nxt = ST_STO_LO; load = 1'b1; reload = t_low;
                end
            end
            ST_STO_LO: begin
                lvl_ok = !scl_s;
                if (expire) begin
                    nxt = ST_STO_SU; load = 1'b1; reload = t_su;
                end
            end
            ST_STO_SU: begin
                lvl_ok = scl_s;
                if (expire) begin
                    nxt = ST_BUS_FREE; load = 1'b1; reload = t_buf;
                end
            end
            ST_BUS_FREE: begin
                lvl_ok = sda_s;
                if (expire) nxt = ST_FINISH;
            end
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Failure flag, cleared by a new request.
    always_ff @(posedge clk) begin
        if (!rst_n)                    fail_r <= 1'b0;
        else if (state == ST_IDLE && go) fail_r <= 1'b0;
        else if (fail_set)             fail_r <= 1'b1;
    end

    // Line drive and status decode.
    always_comb begin
        scl_oe = (state == ST_CLK_LO) || (state == ST_STO_LO);
        sda_oe = (state == ST_STA_HD) || (state == ST_STO_LO) ||
                 (state == ST_STO_SU);
        busy   = (state != ST_IDLE);
        done   = (state == ST_FINISH);
        fail   = (state == ST_FINISH) && fail_r;
    end
endmodule

// File: rtl/bus_unjam_chk.sv
// Property checker for the recovery sequencer, attached by bind.
// Assumes: observes top-level ports only.
module bus_unjam_chk #(
    parameter int MAX_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic go,
    input logic scl_oe,
    input logic sda_oe,
    input logic busy,
    input logic done,
    input logic fail
);
    logic [7:0] lows;
    logic       scl_oe_q;

    // Count SCL low phases within one sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lows <= '0; scl_oe_q <= 1'b0;
        end else begin
            scl_oe_q <= scl_oe;
            if (!busy)                  lows <= '0;
            else if (scl_oe && !scl_oe_q) lows <= lows + 1'b1;
        end
    end

    assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    assert_pulse_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lows <= 8'(MAX_PULSES + 1));

    assert_fail_with_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> done);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_go_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && go) |=> busy);

    assert_sda_scl_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!scl_oe && !$past(scl_oe)));
endmodule

bind bus_unjam_seq bus_unjam_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
    .clk(clk), .rst_n(rst_n), .go(go), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .done(done), .fail(fail));

// File: tb/sim_bus_unjam_seq.sv
// Sweep bench: timing sets x slave release points, expected values computed.
module sim_bus_unjam_seq;
    localparam int CLK_P = 10;
    localparam int CW    = 8;
    localparam int SY    = 2;
    localparam int MP    = 9;

    logic clk = 1'b0, rst_n = 1'b0, go = 1'b0;
    logic [CW-1:0] t_low = '0, t_high = '0, t_su = '0, t_hd = '0, t_buf = '0;
    logic slave_low = 1'b0;
    logic scl_oe, sda_oe, busy, done, fail;
    logic scl_line, sda_line;
    int errors = 0, checks = 0;

    assign scl_line = !scl_oe;
    assign sda_line = !sda_oe && !slave_low;

    always #(CLK_P/2) clk = !clk;

    bus_unjam_seq #(.CNT_W(CW), .SYNC_STAGES(SY), .MAX_PULSES(MP)) u0 (
        .clk(clk), .rst_n(rst_n), .go(go), .t_low(t_low), .t_high(t_high),
        .t_su(t_su), .t_hd(t_hd), .t_buf(t_buf), .scl_in(scl_line),
        .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy),
        .done(done), .fail(fail));

    function automatic int m1(int x);
        return (x < 1) ? 1 : x;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(int tl, int th, int ts, int thd, int tb, int k, bit poke);
        int n = 0, lowc = 0, falls = 0, starts = 0, stops = 0, sdac = 0;
        int p, ok, d, ll, hh;
        logic ps, pd, sl, dl;
        @(negedge clk);
        t_low = CW'(tl); t_high = CW'(th); t_su = CW'(ts); t_hd = CW'(thd);
        t_buf = CW'(tb);
        slave_low = (k > 0);
        ps = 1'b1; pd = !(k > 0);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        while (!done && n < 2000) begin
            sl = scl_line; dl = sda_line;
            if (scl_oe) lowc++;
            if (sda_oe) sdac++;
            if (ps && !sl) falls++;
            if (ps && sl && pd && !dl) starts++;
            if (ps && sl && !pd && dl) stops++;
            slave_low = (falls < k);
            ps = sl; pd = !sda_oe && !slave_low;
            go = (poke && n == 5);
            n++;
            @(negedge clk);
        end
        go = 1'b0;
        ok = (k <= MP);
        p  = ok ? m1(k) : MP;
        ll = SY + m1(tl); hh = SY + m1(th);
        d  = p * (ll + hh);
        if (ok) d += m1(ts) + (SY + m1(thd)) + ll + (SY + m1(ts)) + (SY + m1(tb));
        chk("R7 total cycles go->done", n, d);
        chk("R4 fail flag at done", int'(fail), ok ? 0 : 1);
        chk("R2 SCL low cycles", lowc, ok ? (p + 1) * ll : MP * ll);
        chk("R3 SCL falls", falls, ok ? p + 1 : MP);
        chk("R5 start conditions", starts, ok ? 1 : 0);
        chk("R6 stop conditions", stops, ok ? 1 : 0);
        chk("R6 SDA driven cycles", sdac, ok ? (SY + m1(thd)) + ll + (SY + m1(ts)) : 0);
        @(negedge clk);
        chk("R7 done single cycle", int'(done), 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            chk("R8 idle after ignored go", int'(busy), 0);
            chk("R8 SCL released after", int'(scl_oe), 0);
        end
        slave_low = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 scl_oe in reset", int'(scl_oe), 0);
        chk("R1 sda_oe in reset", int'(sda_oe), 0);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 done/fail in reset", int'(done | fail), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after reset", int'(busy | scl_oe | sda_oe), 0);
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k <= MP + 1; k++) begin
                case (s)
                    0: run_case(0, 0, 0, 0, 0, k, 1'b0);
                    1: run_case(1, 1, 1, 1, 1, k, 1'b0);
                    2: run_case(3, 2, 2, 2, 4, k, 1'b0);
                    default: run_case(5, 3, 1, 4, 2, k, 1'b0);
                endcase
            end
        end
        run_case(2, 2, 2, 2, 2, 4, 1'b1);
        run_case(2, 2, 2, 2, 2, MP + 1, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule